// File: doc/BRIEF.md
# Feedback Divider with Dither Gate

This block runs on the oscillator clock of a line-locked clock generator. It counts oscillator cycles to divide the oscillator down to a feedback clock at the reference rate. The division ratio is a programmable multiplication factor M. The feedback pulse is high for one eighth of each divided period, so its shape resembles a horizontal sync pulse. The controller compares this pulse against the reference.

The same count drives a dither gate. Each divided period has two parts. Cycles before a fractional threshold run at the nominal period. Cycles from the threshold up to M are flagged to run one tuning step long. By moving the threshold, the controller sets how many long cycles occur per reference period. This gives tuning steps finer than the oscillator's own resolution, and the total number of cycles per period stays at M.

The controller raises the enable at the start of each search step and drops it at the end. The count restarts from its first value on every enable, so the feedback edge lines up with the reference again at every step.

Top module: `fbdiv_dither`

## Requirements
- R1: While reset is asserted, `cnt` is 0 and both `fb_clk` and `long_cyc` are low.
- R2: On a clock edge where `run` is low, `cnt` becomes 0, and `fb_clk` and `long_cyc` go low at that same edge.
- R3: On the first edge with `run` high after `cnt` was 0, `cnt` becomes 1. After that, each edge adds 1 to `cnt` while `cnt` is below the effective M.
- R4: When `cnt` equals or exceeds the effective M, the next enabled edge sets `cnt` back to 1. A period is therefore exactly M cycles long.
- R5: `fb_clk` is high exactly while `cnt` lies in 1 through floor(M/8), and low for the rest of the period. Both outputs are registered and change on the same edge as `cnt`.
- R6: For a threshold F with 2 ≤ F < M, `long_cyc` is low for counts 1 through F-1 and high for counts F through M. It is always low when `cnt` is 1.
- R7: When F ≥ M, `long_cyc` stays low for the whole period.
- R8: When F is 0 or 1, `long_cyc` is low only at count 1 and high for counts 2 through M.
- R9: A `mult` value below 8 is treated as M = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enable for the search step; a low level clears the count |
| mult | input | CW | Multiplication factor M |
| frac | input | CW | Threshold F for long cycles |
| fb_clk | output | 1 | Feedback clock, high for floor(M/8) of every M cycles |
| long_cyc | output | 1 | High when the current oscillator cycle runs long |
| cnt | output | CW | Current count, 0 while idle, otherwise 1..M |

## Verification
A wrong count shows up at the ports right away, because `cnt` is a port. A missed wrap shows up one edge after `cnt` reaches M: the next value is M+1 where 1 is expected. A wrong threshold compare or a wrong M/8 truncation appears in the first period after enable, as `long_cyc` or `fb_clk` toggling one count early or late. The bench compares all three outputs on every cycle. It spreads M and F across values just below, at and just above each boundary, so a one-count slip is caught within a single divided period.

// File: rtl/fbdiv_dither.sv
module fbdiv_dither #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] mult,
  input  logic [CW-1:0] frac,
  output logic          fb_clk,
  output logic          long_cyc,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] MMIN = CW'(8);
  localparam logic [CW-1:0] FMIN = CW'(2);

  logic [CW-1:0] meff, hi_end, thr, cnt_n;
  logic          fb_n, long_n;

  assign meff   = (mult < MMIN) ? MMIN : mult;
  assign hi_end = meff >> 3;
  assign thr    = (frac < FMIN) ? FMIN : frac;

  always_comb begin
    if (!run)                          cnt_n = '0;
    else if (cnt == '0 || cnt >= meff) cnt_n = CW'(1);
    else                               cnt_n = cnt + CW'(1);
  end

  assign fb_n   = run && (cnt_n != '0) && (cnt_n <= hi_end);
  assign long_n = run && (frac < meff) && (cnt_n >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      fb_clk   <= 1'b0;
      long_cyc <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      fb_clk   <= fb_n;
      long_cyc <= long_n;
    end
  end

endmodule

module fbdiv_dither_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] mult,
  input logic [CW-1:0] frac,
  input logic          fb_clk,
  input logic          long_cyc,
  input logic [CW-1:0] cnt
);
  logic [CW-1:0] m_ok;
  assign m_ok = (mult < CW'(8)) ? CW'(8) : mult;

  a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !fb_clk && !long_cyc));
  a_r3_start_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |=> cnt == CW'(1));
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && cnt < m_ok) |=> cnt == $past(cnt) + CW'(1));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= m_ok) |=> cnt == CW'(1));
  a_r5_high_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |-> fb_clk);
  a_r5_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (!fb_clk && !long_cyc));
  a_r6_short_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1)) |-> !long_cyc);
  a_r7_no_long: assert property (@(posedge clk) disable iff (!rst_n)
    (frac >= m_ok) |=> !long_cyc);
endmodule

bind fbdiv_dither fbdiv_dither_chk #(.CW(CW)) u_chk (.*);

// File: tb/fbdiv_dither_test.sv
module fbdiv_dither_test;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [CW-1:0] mult = CW'(16);
  logic [CW-1:0] frac = CW'(8);
  logic          fb_clk, long_cyc;
  logic [CW-1:0] cnt;

  int compared = 0;
  int mismatched = 0;
  int ecnt = 0;

  always #5 clk = ~clk;

  fbdiv_dither #(.CW(CW)) uut (.*);

  function automatic int m_of(int m);
    return (m < 8) ? 8 : m;
  endfunction

  function automatic int step(int c, bit en, int m);
    if (!en) return 0;
    if (c == 0 || c >= m_of(m)) return 1;
    return c + 1;
  endfunction

  function automatic bit exp_fb(int c, int m);
    return (c >= 1) && (c <= m_of(m) / 8);
  endfunction

  function automatic bit exp_long(int c, int m, int f);
    int t;
    t = (f < 2) ? 2 : f;
    return (c != 0) && (f < m_of(m)) && (c >= t);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (M=%0d F=%0d)",
               tag, what, act, exp, mult, frac);
    end
  endtask

  task automatic tick();
    string tc, tl;
    @(posedge clk);
    ecnt = step(ecnt, run, int'(mult));
    @(negedge clk);
    if (!run) tc = "R2";
    else if (ecnt == 1) tc = "R4";
    else tc = "R3";
    chk(tc, "cnt", int'(cnt), ecnt);
    chk((mult < 8) ? "R9" : "R5", "fb_clk", int'(fb_clk), int'(exp_fb(ecnt, int'(mult))));
    if (!run) tl = "R2";
    else if (int'(frac) >= m_of(int'(mult))) tl = "R7";
    else if (frac < 2) tl = "R8";
    else tl = "R6";
    chk(tl, "long_cyc", int'(long_cyc), int'(exp_long(ecnt, int'(mult), int'(frac))));
  endtask

  task automatic burst(int m, int f, int periods);
    @(negedge clk);
    run = 1'b0; mult = CW'(m); frac = CW'(f);
    tick();
    run = 1'b1;
    for (int i = 0; i < periods * m_of(m) + 3; i++) tick();
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1", "cnt", int'(cnt), 0);
    chk("R1", "fb_clk", int'(fb_clk), 0);
    chk("R1", "long_cyc", int'(long_cyc), 0);
    @(negedge clk); rst_n = 1'b1;
    ecnt = 0;

    burst(8, 1, 2);
    burst(8, 8, 2);
    burst(8, 7, 2);
    burst(9, 0, 2);
    burst(15, 2, 2);
    burst(16, 15, 2);
    burst(16, 16, 1);
    burst(17, 40, 1);
    burst(5, 3, 2);
    burst(3, 9, 1);
    burst(64, 32, 2);

    for (int k = 0; k < 40; k++) begin
      int m, f, p;
      m = 8 + int'($urandom_range(0, 56));
      f = int'($urandom_range(0, m + 3));
      p = 1 + int'($urandom_range(0, 2));
      burst(m, f, p);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk); run = 1'b0;
        repeat (int'($urandom_range(1, 4))) tick();
      end
    end

    @(negedge clk); run = 1'b0;
    tick();
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule